// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Transmitter

This block turns a stream of stereo sample pairs into one biphase-mark coded serial line. The line format suits consumer and professional two-channel digital audio links. Each frame has two subframes. The left sample goes out first, in the even time slot, and the right sample follows in the odd time slot. Each subframe is 32 bit cells long. The first four cells hold a synchronising preamble. Then come 24 sample bits sent least significant bit first, then a validity bit, a user bit, a channel-status bit and a parity bit.

A host writes the channel-status and user fields for a whole block of 192 frames into four on-chip banks. There is one bank for each field and each side, and each bank holds six 32-bit words. The transmitter then walks the banks frame by frame with no further host action. Sample pairs arrive over a valid/ready handshake into a one-pair buffer. If no pair is waiting when a frame begins, the frame carries silence marked invalid and an underrun pulse is raised.

Timing comes from a single enable, `half_en`, which pulses once per half bit cell. There are 64 such pulses in each subframe. For a 192 kHz stereo rate, `half_en` must pulse at 24.576 MHz, and the clock must run at that rate or faster.

Top module: `bmc_audio_tx`

## Requirements
- R1: After reset, `line_out` is 0, `in_ready` is 1 and `underrun` is 0. The first `half_en` pulse after reset only loads the first subframe, and `line_out` does not change on that pulse. Each later pulse emits one half cell, and a subframe lasts 64 pulses.
- R2: `line_out` changes only on a clock edge where `half_en` is 1. It holds its value through any cycles where `half_en` is 0.
- R3: The preamble fills half cells 0 to 7 of every subframe, first half first. The codes are 11101000 for the left subframe of frame 0, 11100010 for every other left subframe, and 11100100 for every right subframe. These codes apply when the line was 0 just before the preamble. When the line was 1, the code is sent inverted.
- R4: Bit cells 4 to 31 use biphase-mark coding. The line toggles at the start of every cell, and it toggles again in the middle of the cell only when the bit is 1.
- R5: Cells 4 to 27 carry the 24-bit sample, least significant bit in cell 4. The left subframe carries `in_left` and the right subframe carries `in_right`, both from the same accepted pair.
- R6: Cell 28 is the validity bit: 1 only for substituted silence, otherwise 0. Cell 29 is the user bit and cell 30 is the channel-status bit. Cell 31 is set so that cells 4 to 31 hold an even number of ones.
- R7: The channel-status and user bits of frame n (0 to 191) are taken from the bank for that side and field. The bit used is bit n mod 32 of word n/32. The frame count returns to 0 after frame 191, and that frame carries the 11101000 preamble again.
- R8: If no pair is buffered when a left subframe is loaded, both subframes of that frame carry zero audio with validity 1. In that case `underrun` is 1 for exactly the one clock cycle after the loading edge.
- R9: `in_ready` is 1 exactly when the one-pair buffer is empty. A pair is accepted on an edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 in the following cycle. The buffer empties when the left subframe of its frame is loaded.
- R10: A host write with `cfg_we` set to 1 stores `cfg_wdata` into one bank word. `cfg_addr[4]` picks the field (0 channel status, 1 user data), `cfg_addr[3]` picks the side (0 left, 1 right) and `cfg_addr[2:0]` picks the word (0 to 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_en | input | 1 | Half-cell rate enable |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Pair buffer empty, pair will be taken |
| in_left | input | 24 | Left sample, even slot |
| in_right | input | 24 | Right sample, odd slot |
| cfg_we | input | 1 | Bank write strobe |
| cfg_addr | input | 5 | Field, side and word index |
| cfg_wdata | input | 32 | Bank write data |
| line_out | output | 1 | Biphase-mark coded line |
| underrun | output | 1 | One-cycle pulse: a frame started with no sample |

## Verification
`line_out` is registered, so the half cell for a given `half_en` pulse appears right after the rising edge that sees the pulse. The bench raises `half_en` for one cycle and samples at the next falling edge. Each subframe's 64 half cells are compared against a line-level model in the bench. The bench keeps its own level from one subframe to the next and never reads the design's level. `underrun` is sampled at the falling edge right after the last pulse of a right subframe, the edge that loads the next left subframe. `in_ready` is checked half a cycle before and half a cycle after each accepting edge.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

   localparam int SLOT_CELLS = 32;
   localparam int HALF_CELLS = 2 * SLOT_CELLS;
   localparam int SYNC_HALVES = 8;

   typedef enum logic [1:0] {
      SYNC_BLOCK = 2'd0,
      SYNC_LEFT  = 2'd1,
      SYNC_RIGHT = 2'd2
   } sync_kind_e;

   typedef struct packed {
      sync_kind_e  kind;
      logic [31:0] cells;
   } slot_t;

   // half-cell levels of each sync code, first half in bit 7, for a low line before it
   function automatic logic [7:0] sync_code(input sync_kind_e k);
      case (k)
         SYNC_BLOCK: return 8'b1110_1000;
         SYNC_LEFT:  return 8'b1110_0010;
         default:    return 8'b1110_0100;
      endcase
   endfunction

endpackage

// File: rtl/bmc_status_bank.sv
module bmc_status_bank #(
   parameter int BANK_WORDS = 6,
   localparam int IDX_W   = $clog2(BANK_WORDS),
   localparam int FRAME_W = $clog2(BANK_WORDS * 32)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [IDX_W+1:0]   waddr,
   input  logic [31:0]        wdata,
   input  logic [FRAME_W-1:0] frame,
   input  logic               side,
   output logic               stat_bit,
   output logic               user_bit
);

   localparam int SEL_W = FRAME_W - 5;

   logic [3:0] bank_bit;
   logic [SEL_W-1:0] word_sel;
   logic [4:0] bit_sel;

   assign word_sel = frame[FRAME_W-1:5];
   assign bit_sel  = frame[4:0];

   // bank g: g[1] = field (0 status, 1 user), g[0] = side (0 left, 1 right)
   for (genvar g = 0; g < 4; g++) begin : g_bank
      logic [31:0] mem [BANK_WORDS];
      logic hit;
      assign hit = we && (waddr[IDX_W+1:IDX_W] == 2'(g))
                   && (int'(waddr[IDX_W-1:0]) < BANK_WORDS);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < BANK_WORDS; w++) mem[w] <= '0;
         end else if (hit) begin
            mem[waddr[IDX_W-1:0]] <= wdata;
         end
      end

      logic [31:0] rd_word;
      assign rd_word = mem[word_sel];
      assign bank_bit[g] = rd_word[bit_sel];
   end

   assign stat_bit = side ? bank_bit[1] : bank_bit[0];
   assign user_bit = side ? bank_bit[3] : bank_bit[2];

endmodule

// File: rtl/bmc_slot_builder.sv
module bmc_slot_builder
   import bmc_tx_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  sync_kind_e           kind,
   input  logic [SAMPLE_W-1:0]  sample,
   input  logic                 vbit,
   input  logic                 ubit,
   input  logic                 cbit,
   output slot_t                slot
);

   logic [31:0] body;

   if (SAMPLE_W == 24) begin : g_full
      // auxiliary nibble carries the sample's four low bits
      always_comb begin
         body        = '0;
         body[27:4]  = sample;
      end
   end else begin : g_short
      always_comb begin
         body                  = '0;
         body[27 -: SAMPLE_W]  = sample;
      end
   end

   always_comb begin
      slot.kind        = kind;
      slot.cells       = body;
      slot.cells[28]   = vbit;
      slot.cells[29]   = ubit;
      slot.cells[30]   = cbit;
      slot.cells[31]   = ^{cbit, ubit, vbit, body[27:4]};
   end

endmodule

// File: rtl/bmc_line_coder.sv
module bmc_line_coder
   import bmc_tx_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   half_en,
   input  slot_t  next_slot,
   output logic   load,
   output logic   line
);

   logic [5:0] half_idx;
   logic       running;
   logic       base_lvl;
   logic       line_q;
   logic       nxt_lvl;
   slot_t      cur;

   assign load = half_en && (half_idx == 6'(HALF_CELLS - 1));

   always_comb begin
      logic [7:0] code;
      logic       ref_lvl;
      code    = sync_code(cur.kind);
      ref_lvl = (half_idx == 6'd0) ? line_q : base_lvl;
      if (half_idx < 6'(SYNC_HALVES))
         nxt_lvl = code[3'd7 - half_idx[2:0]] ^ ref_lvl;
      else if (!half_idx[0])
         nxt_lvl = ~line_q;
      else
         nxt_lvl = line_q ^ cur.cells[half_idx[5:1]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_idx <= 6'(HALF_CELLS - 1);
         running  <= 1'b0;
         base_lvl <= 1'b0;
         line_q   <= 1'b0;
         cur      <= '0;
      end else if (half_en) begin
         half_idx <= half_idx + 6'd1;
         if (load) begin
            cur     <= next_slot;
            running <= 1'b1;
         end
         if (running) begin
            line_q <= nxt_lvl;
            if (half_idx == 6'd0) base_lvl <= line_q;
         end
      end
   end

   assign line = line_q;

   a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      !half_en |=> $stable(line_q));

   a_r4_cell_start_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (half_en && running && half_idx >= 6'(SYNC_HALVES) && !half_idx[0])
      |=> (line_q != $past(line_q)));

   a_r6_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (^next_slot.cells[31:4] == 1'b0));

endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
   import bmc_tx_pkg::*;
#(
   parameter int SAMPLE_W   = 24,
   parameter int BANK_WORDS = 6,
   localparam int IDX_W      = $clog2(BANK_WORDS),
   localparam int FRAME_W    = $clog2(BANK_WORDS * 32),
   localparam int LAST_FRAME = BANK_WORDS * 32 - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                half_en,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   input  logic                cfg_we,
   input  logic [IDX_W+1:0]    cfg_addr,
   input  logic [31:0]         cfg_wdata,
   output logic                line_out,
   output logic                underrun
);

   if (SAMPLE_W < 20 || SAMPLE_W > 24) begin : g_bad_width
      $error("SAMPLE_W must lie in 20..24");
   end
   if (BANK_WORDS < 2 || BANK_WORDS > 8) begin : g_bad_depth
      $error("BANK_WORDS must lie in 2..8");
   end

   logic                full;
   logic [SAMPLE_W-1:0] buf_l, buf_r, hold_r;
   logic                hold_silent;
   logic [FRAME_W-1:0]  frame;
   logic                side_r;
   logic                ur_q;
   logic                load;
   logic                accept;
   logic                stat_bit, user_bit;
   sync_kind_e          kind;
   logic [SAMPLE_W-1:0] smp;
   logic                vbit;
   slot_t               slot;

   assign in_ready = !full;
   assign accept   = in_valid && !full;

   bmc_status_bank #(.BANK_WORDS(BANK_WORDS)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
      .frame(frame), .side(side_r), .stat_bit(stat_bit), .user_bit(user_bit)
   );

   always_comb begin
      if (side_r) begin
         kind = SYNC_RIGHT;
         smp  = hold_r;
         vbit = hold_silent;
      end else begin
         kind = (frame == '0) ? SYNC_BLOCK : SYNC_LEFT;
         smp  = full ? buf_l : '0;
         vbit = !full;
      end
   end

   bmc_slot_builder #(.SAMPLE_W(SAMPLE_W)) u_build (
      .kind(kind), .sample(smp), .vbit(vbit), .ubit(user_bit), .cbit(stat_bit),
      .slot(slot)
   );

   bmc_line_coder u_coder (
      .clk(clk), .rst_n(rst_n), .half_en(half_en), .next_slot(slot),
      .load(load), .line(line_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full        <= 1'b0;
         buf_l       <= '0;
         buf_r       <= '0;
         hold_r      <= '0;
         hold_silent <= 1'b0;
         frame       <= '0;
         side_r      <= 1'b0;
         ur_q        <= 1'b0;
      end else begin
         ur_q <= load && !side_r && !full;
         if (accept) begin
            full  <= 1'b1;
            buf_l <= in_left;
            buf_r <= in_right;
         end else if (load && !side_r) begin
            full <= 1'b0;
         end
         if (load) begin
            if (!side_r) begin
               hold_r      <= full ? buf_r : '0;
               hold_silent <= !full;
               side_r      <= 1'b1;
            end else begin
               side_r <= 1'b0;
               frame  <= (frame == FRAME_W'(LAST_FRAME)) ? '0 : frame + 1'b1;
            end
         end
      end
   end

   assign underrun = ur_q;

   a_r8_underrun_single: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> !underrun);

   a_r9_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   a_r7_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (load && side_r && frame == FRAME_W'(LAST_FRAME)) |=> (frame == '0));

   a_r3_block_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !side_r && frame == '0) |-> (slot.kind == SYNC_BLOCK));

endmodule

// File: tb/sim_bmc_audio_tx.sv
module sim_bmc_audio_tx;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        half_en;
   logic        in_valid;
   logic        in_ready;
   logic [23:0] in_left, in_right;
   logic        cfg_we;
   logic [4:0]  cfg_addr;
   logic [31:0] cfg_wdata;
   logic        line_out;
   logic        underrun;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   logic lvl;

   localparam int UR_FRAME = 11;
   localparam int LAST_F   = 192;

   localparam logic [47:0] VEC [8] = '{
      {24'h000000, 24'h000000},
      {24'hFFFFFF, 24'hFFFFFF},
      {24'h800000, 24'h000001},
      {24'hAAAAAA, 24'h555555},
      {24'h123456, 24'hFEDCBA},
      {24'h00000F, 24'hF00000},
      {24'h7FFFFF, 24'h800001},
      {24'h0F0F0F, 24'hC3C3C3}
   };

   always #4 clk = ~clk;

   bmc_audio_tx u0 (
      .clk(clk), .rst_n(rst_n), .half_en(half_en), .in_valid(in_valid),
      .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .line_out(line_out), .underrun(underrun)
   );

   function automatic logic [31:0] bank_val(input int f, input int s, input int w);
      return 32'h9E3779B9 * 32'(f * 16 + s * 8 + w + 1) ^ 32'(w * 32'h01010101);
   endfunction

   function automatic logic bank_bit(input int f, input int s, input int n);
      logic [31:0] v;
      v = bank_val(f, s, n / 32);
      return v[n % 32];
   endfunction

   function automatic logic [31:0] mk_word(input logic [23:0] smp, input logic v,
                                           input logic u, input logic c);
      logic [31:0] w;
      w = '0;
      w[27:4] = smp;
      w[28] = v; w[29] = u; w[30] = c;
      w[31] = ^w[30:4];
      return w;
   endfunction

   function automatic logic [47:0] pair_for(input int f);
      if (f < 8) return VEC[f];
      return {24'(f * 32'h000B5D13) ^ 24'h3C0F0F, 24'(f * 32'h00071A2B) ^ 24'hA50A50};
   endfunction

   task automatic fail(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
   endtask

   task automatic tick();
      half_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      half_en = 1'b0;
   endtask

   task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic push(input logic [47:0] p);
      n_cmp++;
      if (in_ready !== 1'b1) fail("R9 ready before push", 32'(in_ready), 1);
      in_valid = 1'b1; in_left = p[47:24]; in_right = p[23:0];
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      n_cmp++;
      if (in_ready !== 1'b0) fail("R9 ready after accept", 32'(in_ready), 0);
   endtask

   // compares 64 half cells of one subframe against the bench's own level model
   task automatic check_sub(input string req, input logic [7:0] code, input logic [31:0] w,
                            input int gap, output logic ur);
      logic e, base, act_b, exp_b;
      int bad_k;
      bad_k = -1; base = lvl; act_b = 0; exp_b = 0; ur = 0;
      for (int k = 0; k < 64; k++) begin
         if (k < 8) e = code[7-k] ^ base;
         else if (k % 2 == 0) e = ~lvl;
         else e = lvl ^ w[k/2];
         if (gap > 0 && k == 20) begin
            logic held;
            held = line_out;
            repeat (gap) @(negedge clk);
            n_cmp++;
            if (line_out !== held) fail("R2 line moved without tick", 32'(line_out), 32'(held));
         end
         tick();
         if (line_out !== e && bad_k < 0) begin
            bad_k = k; act_b = line_out; exp_b = e;
         end
         lvl = e;
         if (k == 63) ur = underrun;
      end
      n_cmp++;
      if (bad_k >= 0) begin
         $display("FAIL %s half cell %0d actual=%0b expected=%0b", req, bad_k, act_b, exp_b);
         n_bad++;
      end
   endtask

   initial begin
      logic ur;
      logic [47:0] p;
      logic [23:0] sl, sr;
      logic v;
      int n;
      rst_n = 1'b0; half_en = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0;
      cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      n_cmp++; if (line_out !== 1'b0) fail("R1 line after reset", 32'(line_out), 0);
      n_cmp++; if (in_ready !== 1'b1) fail("R1 ready after reset", 32'(in_ready), 1);
      n_cmp++; if (underrun !== 1'b0) fail("R1 underrun after reset", 32'(underrun), 0);

      // R10: fill the four banks; addr = {field, side, word}
      for (int f = 0; f < 2; f++)
         for (int s = 0; s < 2; s++)
            for (int w = 0; w < 6; w++)
               cfg_write({1'(f), 1'(s), 3'(w)}, bank_val(f, s, w));

      push(VEC[0]);
      tick();   // R1: priming pulse loads without emitting
      n_cmp++; if (line_out !== 1'b0) fail("R1 line after priming pulse", 32'(line_out), 0);
      lvl = 1'b0;

      // vector table walk, then continuing frames up to the block wrap (R3 R4 R5 R6 R7 R8)
      for (int f = 0; f <= LAST_F; f++) begin
         n = f % 192;
         if (f + 1 <= LAST_F && f + 1 != UR_FRAME) push(pair_for(f + 1));
         if (f == UR_FRAME) begin
            sl = '0; sr = '0; v = 1'b1;
         end else begin
            p = pair_for(f); sl = p[47:24]; sr = p[23:0]; v = 1'b0;
         end
         check_sub((n == 0) ? "R3/R5/R6/R7 left block start" : "R3/R4/R5/R6/R8 left",
                   (n == 0) ? 8'b1110_1000 : 8'b1110_0010,
                   mk_word(sl, v, bank_bit(1, 0, n), bank_bit(0, 0, n)),
                   (f == 2) ? 3 : 0, ur);
         check_sub("R3/R4/R5/R6/R7 right", 8'b1110_0100,
                   mk_word(sr, v, bank_bit(1, 1, n), bank_bit(0, 1, n)), 0, ur);
         if (f < LAST_F) begin
            n_cmp++;
            if (ur !== logic'(f + 1 == UR_FRAME))
               fail("R8 underrun pulse", 32'(ur), 32'(f + 1 == UR_FRAME));
         end
         if (f + 1 == UR_FRAME) begin
            @(negedge clk);
            n_cmp++; if (underrun !== 1'b0) fail("R8 underrun width", 32'(underrun), 0);
         end
      end

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule